// File: doc/BRIEF.md
# Linked-list DMA channel engine

This block is a single data-movement channel. Software loads a source address, a destination address, an element count with element width, increment flags, burst length and a pacing mode, plus a pointer to a further descriptor. The channel then reads elements from the source and writes them to the destination through one valid/ready memory master port. Up to four elements are staged in an internal FIFO between the read and write phases. Data always moves in one direction only, from source to destination.

When a segment's count reaches zero and the descriptor pointer is non-zero, the channel reads a four-word descriptor from memory and carries on with it. This chains non-contiguous regions into one scatter-gather job. In paced mode, a peripheral starts each group of elements: a single request moves one element and a burst request moves a programmed number of elements. A completion flag and a bus-error flag are kept unmasked, and a mask selects which of them drive the interrupt line.

Top module: `llist_dma_chan`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and `mem_req` is low.
- R2: A segment moves exactly the number of elements in CTRL[11:0]. The element width is set by CTRL[13:12]: 0 selects 8-bit, 1 selects 16-bit and 2 selects 32-bit. `mem_size` carries that code, data is right-aligned on the memory port, and a pending request holds its address and direction until it is granted.
- R3: CTRL[14] makes the source address step and CTRL[15] makes the destination address step, each by the element size in bytes per element. With a flag clear, that address stays fixed, so a fixed destination ends up holding the last element.
- R4: The burst length is set by CTRL[17:16]: 0 means 1 element, 1 means 4 and 2 means 8. A group is the burst length or the remaining count, whichever is smaller. No more than 4 elements are read ahead of their writes.
- R5: When CTRL[18] is set, the channel makes no bus access until a request arrives. `per_sreq` moves one element and `per_breq` moves one group. `per_done` pulses for one cycle after the group's last write.
- R6: When a segment ends and the next pointer is non-zero, the channel reads the words at next, next+4, next+8 and next+12 as source, destination, next pointer and control, in that order, and then continues with them.
- R7: When the last element of a segment whose next pointer is zero is written, raw status bit 0 (completion) sets and CFG bit 0 (enable) clears.
- R8: An error response on a granted access sets raw status bit 1 and clears the enable. No further bus request follows.
- R9: Writing 1s to the clear register (offset 0x18) clears the matching raw bits. A hardware set in the same cycle wins over the clear.
- R10: CFG bit 1 masks completion and CFG bit 2 masks error. `irq` is the OR of raw AND mask, and the masked status reads at offset 0x1C. The register offsets are: 0x00 source, 0x04 destination, 0x08 next, 0x0C control, 0x10 config and 0x14 raw status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address |
| mem_size | output | 2 | Access width code |
| mem_wdata | output | DW | Write data, right-aligned |
| mem_gnt | input | 1 | Access accepted this cycle |
| mem_rdata | input | DW | Read data, valid with grant |
| mem_err | input | 1 | Error response, valid with grant |
| per_sreq | input | 1 | Peripheral single-element request |
| per_breq | input | 1 | Peripheral burst request |
| per_done | output | 1 | Group finished pulse (paced mode) |
| irq | output | 1 | Interrupt line |

## Verification
Two events can land in the same cycle: the hardware setting the completion flag as the last write is granted, and software writing the clear register. The bench provokes this from its memory model. It counts granted writes, and on the grant of the final write it also drives a clear of bit 0 on the register port in that same cycle. It then reads the raw status and expects bit 0 still set, because the hardware set has priority.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
   typedef enum logic [1:0] {CH_IDLE, CH_READ, CH_WRITE, CH_FETCH} ch_state_e;

   localparam int WID_LSB  = 12;
   localparam int SINC_BIT = 14;
   localparam int DINC_BIT = 15;
   localparam int BST_LSB  = 16;
   localparam int PACE_BIT = 18;

   localparam logic [2:0] RI_SRC = 3'd0;
   localparam logic [2:0] RI_DST = 3'd1;
   localparam logic [2:0] RI_NXT = 3'd2;
   localparam logic [2:0] RI_CTL = 3'd3;
   localparam logic [2:0] RI_CFG = 3'd4;
   localparam logic [2:0] RI_RAW = 3'd5;
   localparam logic [2:0] RI_CLR = 3'd6;
   localparam logic [2:0] RI_MSK = 3'd7;

   function automatic logic [2:0] unit_bytes(input logic [1:0] code);
      case (code)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

   function automatic logic [3:0] burst_elems(input logic [1:0] code);
      case (code)
         2'd0:    return 4'd1;
         2'd1:    return 4'd4;
         default: return 4'd8;
      endcase
   endfunction
endpackage

// File: rtl/lldma_fifo.sv
module lldma_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       push,
   input  logic [W-1:0]               wdata,
   input  logic                       pop,
   output logic [W-1:0]               rdata,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [W-1:0]  store [DEPTH];
   logic [PW-1:0] wp, rp, wp_nx, rp_nx;

   generate
      if (POW2) begin : g_wrap_free
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_nx = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   assign rdata = store[rp];
   assign full  = (count == CW'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0; rp <= '0; count <= '0;
      end else if (flush) begin
         wp <= '0; rp <= '0; count <= '0;
      end else begin
         if (push) wp <= wp_nx;
         if (pop)  rp <= rp_nx;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) store[wp] <= wdata;
   end
endmodule

// File: rtl/lldma_irq.sv
module lldma_irq #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] mask,
   output logic [N-1:0] raw,
   output logic [N-1:0] masked,
   output logic         irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw <= '0;
      else        raw <= (raw & ~clr) | set;
   end

   assign masked = raw & mask;
   assign irq    = |masked;
endmodule

// File: rtl/llist_dma_chan.sv
module llist_dma_chan
   import lldma_pkg::*;
#(
   parameter int AW         = 32,
   parameter int DW         = 32,
   parameter int CNT_W      = 12,
   parameter int FIFO_DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [4:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [1:0]    mem_size,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_gnt,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_err,
   input  logic          per_sreq,
   input  logic          per_breq,
   output logic          per_done,
   output logic          irq
);
   localparam int CW = $clog2(FIFO_DEPTH + 1);

   if (DW != 32)                    begin : g_bad_dw  $error("DW must be 32"); end
   if (AW < 8 || AW > 32)           begin : g_bad_aw  $error("AW out of range"); end
   if (CNT_W < 4 || CNT_W > 12)     begin : g_bad_cnt $error("CNT_W out of range"); end
   if (FIFO_DEPTH < 1)              begin : g_bad_dep $error("FIFO_DEPTH too small"); end

   ch_state_e      st;
   logic [AW-1:0]  src_q, dst_q, nxt_q, tmp_src, tmp_dst, tmp_nxt;
   logic [31:0]    ctl_q;
   logic [2:0]     cfg_q;
   logic [1:0]     fidx;
   logic [3:0]     grp_left;
   logic [CW-1:0]  bcnt, bcnt_nx, fifo_cnt;
   logic           done_q;

   logic [1:0]     wcode;
   logic [CNT_W-1:0] rem, blen_c;
   logic [3:0]     grp_burst;
   logic           paced;
   logic [AW-1:0]  src_step, dst_step;
   logic [DW-1:0]  elem_mask, fifo_rdata;
   logic           bus_ok, bus_err, fifo_push, fifo_pop, fifo_full, set_tc;
   logic [1:0]     irq_raw, irq_msk, irq_clr;
   logic [2:0]     reg_idx;

   assign reg_idx   = reg_addr[4:2];
   assign wcode     = ctl_q[WID_LSB +: 2];
   assign rem       = ctl_q[CNT_W-1:0];
   assign paced     = ctl_q[PACE_BIT];
   assign blen_c    = CNT_W'(burst_elems(ctl_q[BST_LSB +: 2]));
   assign grp_burst = (rem < blen_c) ? 4'(rem) : 4'(blen_c);
   assign src_step  = ctl_q[SINC_BIT] ? AW'(unit_bytes(wcode)) : '0;
   assign dst_step  = ctl_q[DINC_BIT] ? AW'(unit_bytes(wcode)) : '0;
   assign elem_mask = (wcode == 2'd0) ? DW'(32'h0000_00FF) :
                      (wcode == 2'd1) ? DW'(32'h0000_FFFF) : '1;
   assign bcnt_nx   = bcnt + 1'b1;

   assign mem_req   = (st != CH_IDLE);
   assign mem_we    = (st == CH_WRITE);
   assign mem_size  = (st == CH_FETCH) ? 2'd2 : wcode;
   assign mem_addr  = (st == CH_READ)  ? src_q :
                      (st == CH_WRITE) ? dst_q : nxt_q + AW'({fidx, 2'b00});
   assign mem_wdata = fifo_rdata & elem_mask;
   assign bus_ok    = mem_req & mem_gnt & ~mem_err;
   assign bus_err   = mem_req & mem_gnt & mem_err;
   assign fifo_push = (st == CH_READ)  & bus_ok;
   assign fifo_pop  = (st == CH_WRITE) & bus_ok;
   assign set_tc    = (fifo_pop && rem == CNT_W'(1) && nxt_q == '0) ||
                      (st == CH_IDLE && cfg_q[0] && rem == '0 && nxt_q == '0);
   assign irq_clr   = (reg_we && reg_idx == RI_CLR) ? reg_wdata[1:0] : 2'b00;
   assign per_done  = done_q;

   lldma_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(bus_err),
      .push(fifo_push), .wdata(mem_rdata & elem_mask),
      .pop(fifo_pop), .rdata(fifo_rdata), .count(fifo_cnt), .full(fifo_full)
   );

   lldma_irq #(.N(2)) u_irq (
      .clk(clk), .rst_n(rst_n), .set({bus_err, set_tc}), .clr(irq_clr),
      .mask(cfg_q[2:1]), .raw(irq_raw), .masked(irq_msk), .irq(irq)
   );

   always_comb begin
      case (reg_idx)
         RI_SRC:  reg_rdata = 32'(src_q);
         RI_DST:  reg_rdata = 32'(dst_q);
         RI_NXT:  reg_rdata = 32'(nxt_q);
         RI_CTL:  reg_rdata = ctl_q;
         RI_CFG:  reg_rdata = {29'd0, cfg_q};
         RI_RAW:  reg_rdata = {30'd0, irq_raw};
         RI_MSK:  reg_rdata = {30'd0, irq_msk};
         default: reg_rdata = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= CH_IDLE;
         src_q <= '0; dst_q <= '0; nxt_q <= '0; ctl_q <= '0; cfg_q <= '0;
         tmp_src <= '0; tmp_dst <= '0; tmp_nxt <= '0;
         fidx <= '0; grp_left <= '0; bcnt <= '0; done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (reg_we) begin
            case (reg_idx)
               RI_SRC:  src_q <= AW'(reg_wdata);
               RI_DST:  dst_q <= AW'(reg_wdata);
               RI_NXT:  nxt_q <= AW'(reg_wdata);
               RI_CTL:  ctl_q <= reg_wdata;
               RI_CFG:  cfg_q <= reg_wdata[2:0];
               default: ;
            endcase
         end
         case (st)
            CH_IDLE: if (cfg_q[0]) begin
               if (rem != '0) begin
                  bcnt <= '0;
                  if (!paced || per_breq) begin
                     grp_left <= grp_burst; st <= CH_READ;
                  end else if (per_sreq) begin
                     grp_left <= 4'd1; st <= CH_READ;
                  end
               end else if (nxt_q != '0) begin
                  fidx <= '0; st <= CH_FETCH;
               end else begin
                  cfg_q[0] <= 1'b0;
               end
            end
            CH_READ: if (bus_err) begin
               cfg_q[0] <= 1'b0; st <= CH_IDLE;
            end else if (bus_ok) begin
               src_q <= src_q + src_step;
               bcnt  <= bcnt_nx;
               if (32'(bcnt_nx) == 32'(grp_left) || 32'(bcnt_nx) == FIFO_DEPTH)
                  st <= CH_WRITE;
            end
            CH_WRITE: if (bus_err) begin
               cfg_q[0] <= 1'b0; st <= CH_IDLE;
            end else if (bus_ok) begin
               dst_q <= dst_q + dst_step;
               ctl_q[CNT_W-1:0] <= rem - 1'b1;
               grp_left <= grp_left - 1'b1;
               if (grp_left == 4'd1) begin
                  done_q <= paced;
                  if (rem == CNT_W'(1) && nxt_q != '0) begin
                     fidx <= '0; st <= CH_FETCH;
                  end else begin
                     st <= CH_IDLE;
                     if (rem == CNT_W'(1)) cfg_q[0] <= 1'b0;
                  end
               end else if (fifo_cnt == CW'(1)) begin
                  bcnt <= '0; st <= CH_READ;
               end
            end
            CH_FETCH: if (bus_err) begin
               cfg_q[0] <= 1'b0; st <= CH_IDLE;
            end else if (bus_ok) begin
               fidx <= fidx + 1'b1;
               case (fidx)
                  2'd0: tmp_src <= AW'(mem_rdata);
                  2'd1: tmp_dst <= AW'(mem_rdata);
                  2'd2: tmp_nxt <= AW'(mem_rdata);
                  default: begin
                     src_q <= tmp_src; dst_q <= tmp_dst; nxt_q <= tmp_nxt;
                     ctl_q <= 32'(mem_rdata);
                     st <= CH_IDLE;
                  end
               endcase
            end
            default: st <= CH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/llist_dma_chan_chk.sv
module llist_dma_chan_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req,
   input logic          mem_gnt,
   input logic          mem_err,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic          set_tc,
   input logic [1:0]    raw,
   input logic          chan_en,
   input logic          fifo_push,
   input logic          fifo_full
);
   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push |-> !fifo_full);

   a_r7_tc_disables: assert property (@(posedge clk) disable iff (!rst_n)
      set_tc |=> !chan_en);

   a_r8_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_gnt && mem_err |=> !mem_req && !chan_en && raw[1]);

   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_tc |=> raw[0]);
endmodule

bind llist_dma_chan llist_dma_chan_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_gnt(mem_gnt),
   .mem_err(mem_err), .mem_we(mem_we), .mem_addr(mem_addr),
   .set_tc(set_tc), .raw(irq_raw), .chan_en(cfg_q[0]),
   .fifo_push(fifo_push), .fifo_full(fifo_full)
);

// File: tb/tb_llist_dma_chan.sv
`timescale 1ns/1ps
module tb_llist_dma_chan;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        t_we = 1'b0, c_we = 1'b0;
   logic [4:0]  t_addr = '0;
   logic [31:0] t_wdata = '0;
   logic        reg_we;
   logic [4:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic        mem_req, mem_we, mem_gnt = 1'b0, mem_err = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
   logic [1:0]  mem_size;
   logic        per_sreq = 1'b0, per_breq = 1'b0, per_done, irq;

   logic [7:0]  mem [0:1023];
   logic [7:0]  expm [0:1023];
   int compared = 0, mismatched = 0, cyc = 0;
   int acc_count = 0, wr_count = 0, err_at = -1, collide_at = -1;
   bit rnd_gnt = 1'b1, collide_en = 1'b0;

   assign reg_we    = t_we | c_we;
   assign reg_addr  = c_we ? 5'h18 : t_addr;
   assign reg_wdata = c_we ? 32'd1 : t_wdata;

   llist_dma_chan dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
      .mem_err(mem_err), .per_sreq(per_sreq), .per_breq(per_breq),
      .per_done(per_done), .irq(irq)
   );

   always #4 clk = ~clk;

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         compared++; mismatched++;
         $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
         summary();
         $finish;
      end
   end

   function automatic int nbytes(input logic [1:0] s);
      return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
   endfunction

   always @(negedge clk) begin
      bit g;
      c_we = 1'b0; mem_gnt = 1'b0; mem_err = 1'b0;
      if (rst_n && mem_req) begin
         g = !rnd_gnt || ($urandom % 3 != 0);
         if (collide_en && mem_we && wr_count == collide_at) g = 1'b1;
         if (g) begin
            mem_gnt = 1'b1;
            if (acc_count == err_at) mem_err = 1'b1;
            else if (mem_we) begin
               for (int b = 0; b < nbytes(mem_size); b++)
                  mem[(mem_addr + b) % 1024] = mem_wdata[8*b +: 8];
               if (collide_en && wr_count == collide_at) c_we = 1'b1;
               wr_count++;
            end else begin
               mem_rdata = '0;
               for (int b = 0; b < nbytes(mem_size); b++)
                  mem_rdata[8*b +: 8] = mem[(mem_addr + b) % 1024];
            end
            acc_count++;
         end
      end
   end

   task automatic check(input string req, input bit ok, input longint act, input longint expv);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   task automatic reg_write(input int idx, input logic [31:0] d);
      @(negedge clk); t_we = 1'b1; t_addr = 5'(idx * 4); t_wdata = d;
      @(negedge clk); t_we = 1'b0;
   endtask

   task automatic reg_read(input int idx, output logic [31:0] d);
      @(negedge clk); t_addr = 5'(idx * 4); #1; d = reg_rdata;
   endtask

   function automatic logic [31:0] mk_ctl(input int cnt, input int w, input bit si,
                                          input bit di, input int b, input bit p);
      return 32'(cnt) | (32'(w) << 12) | (32'(si) << 14) | (32'(di) << 15) |
             (32'(b) << 16) | (32'(p) << 18);
   endfunction

   task automatic snap();
      for (int i = 0; i < 1024; i++) expm[i] = mem[i];
   endtask

   task automatic model_seg(input int src, input int dst, input int cnt, input int w,
                            input bit si, input bit di);
      int nb;
      nb = (w == 0) ? 1 : (w == 1) ? 2 : 4;
      for (int i = 0; i < cnt; i++)
         for (int b = 0; b < nb; b++)
            expm[(dst + (di ? i * nb : 0) + b) % 1024] = mem[(src + (si ? i * nb : 0) + b) % 1024];
   endtask

   task automatic mem_compare(input string req);
      int bad, first;
      bad = 0; first = -1;
      for (int i = 0; i < 1024; i++)
         if (mem[i] !== expm[i]) begin bad++; if (first < 0) first = i; end
      if (first < 0) check(req, 1'b1, 0, 0);
      else check({req, " memory byte"}, 1'b0, mem[first], expm[first]);
   endtask

   task automatic put_word(input int a, input logic [31:0] d);
      for (int b = 0; b < 4; b++) mem[(a + b) % 1024] = d[8*b +: 8];
   endtask

   task automatic wait_irq(input string req);
      int n;
      n = 0;
      while (!irq && n < 20000) begin @(negedge clk); n++; end
      check(req, irq === 1'b1, irq, 1);
   endtask

   task automatic wait_done(input string req);
      int n;
      n = 0;
      while (!per_done && n < 20000) begin @(negedge clk); n++; end
      check(req, per_done === 1'b1, per_done, 1);
   endtask

   task automatic clear_all();
      logic [31:0] d;
      reg_write(6, 32'h3);
      reg_read(5, d);
      check("R9 clear raw", d == 0, d, 0);
      check("R9 irq low after clear", irq == 1'b0, irq, 0);
   endtask

   initial begin
      logic [31:0] d;
      int seed_dummy, src, dst, cnt, w, b, nb;
      bit si, di;
      seed_dummy = $urandom(32'd2718);
      for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 irq", irq == 1'b0, irq, 0);
      check("R1 mem_req", mem_req == 1'b0, mem_req, 0);
      for (int i = 0; i < 8; i++) begin
         reg_read(i, d);
         check("R1 register zero", d == 0, d, 0);
      end

      // R2 R3 R4 R7 R10 random segments
      for (int k = 0; k < 24; k++) begin
         w = $urandom % 3; b = $urandom % 3; cnt = 1 + $urandom % 20;
         si = 1'($urandom); di = 1'($urandom);
         src = $urandom % 128; dst = 512 + $urandom % 180;
         nb = (w == 0) ? 1 : (w == 1) ? 2 : 4;
         snap(); model_seg(src, dst, cnt, w, si, di);
         reg_write(0, 32'(src)); reg_write(1, 32'(dst)); reg_write(2, 0);
         reg_write(3, mk_ctl(cnt, w, si, di, b, 0));
         reg_write(4, 32'h3);
         wait_irq("R10 completion irq");
         mem_compare("R2 R3 R4 copy");
         reg_read(5, d); check("R7 raw completion", d == 1, d, 1);
         reg_read(7, d); check("R10 masked status", d == 1, d, 1);
         reg_read(4, d); check("R7 enable cleared", d[0] == 1'b0, d[0], 0);
         reg_read(1, d);
         check("R3 final destination", d == 32'(dst + (di ? cnt * nb : 0)), d, dst + (di ? cnt * nb : 0));
         clear_all();
      end

      // R6 chained descriptors
      put_word(896, 40);  put_word(900, 520); put_word(904, 912); put_word(908, mk_ctl(3, 2, 1, 1, 2, 0));
      put_word(912, 70);  put_word(916, 650); put_word(920, 928); put_word(924, mk_ctl(7, 0, 1, 0, 0, 0));
      put_word(928, 100); put_word(932, 700); put_word(936, 0);   put_word(940, mk_ctl(4, 1, 0, 1, 1, 0));
      snap();
      model_seg(10, 600, 5, 1, 1, 1); model_seg(40, 520, 3, 2, 1, 1);
      model_seg(70, 650, 7, 0, 1, 0); model_seg(100, 700, 4, 1, 0, 1);
      reg_write(0, 10); reg_write(1, 600); reg_write(2, 896);
      reg_write(3, mk_ctl(5, 1, 1, 1, 1, 0));
      reg_write(4, 32'h3);
      wait_irq("R6 chain completion");
      mem_compare("R6 chain data");
      reg_read(1, d); check("R6 last destination", d == 708, d, 708);
      reg_read(2, d); check("R6 next pointer zero", d == 0, d, 0);
      reg_read(0, d); check("R3 fixed source unchanged", d == 100, d, 100);
      clear_all();

      // R5 paced single and burst requests
      acc_count = 0; wr_count = 0;
      snap(); model_seg(20, 760, 6, 2, 1, 1);
      reg_write(0, 20); reg_write(1, 760); reg_write(2, 0);
      reg_write(3, mk_ctl(6, 2, 1, 1, 1, 1));
      reg_write(4, 32'h1);
      repeat (20) @(negedge clk);
      check("R5 no access before request", acc_count == 0, acc_count, 0);
      per_sreq = 1'b1; @(negedge clk); per_sreq = 1'b0;
      wait_done("R5 single done");
      check("R5 single moves one", wr_count == 1, wr_count, 1);
      repeat (5) @(negedge clk);
      check("R5 idle between requests", wr_count == 1, wr_count, 1);
      per_breq = 1'b1; @(negedge clk); per_breq = 1'b0;
      wait_done("R5 burst done");
      check("R5 burst moves four", wr_count == 5, wr_count, 5);
      per_breq = 1'b1; @(negedge clk); per_breq = 1'b0;
      wait_done("R5 short burst done");
      check("R4 burst capped by remaining", wr_count == 6, wr_count, 6);
      @(negedge clk);
      reg_read(5, d); check("R7 paced completion", d == 1, d, 1);
      mem_compare("R5 paced data");
      clear_all();

      // R8 R10 error with mask on
      acc_count = 0; err_at = 2;
      reg_write(0, 0); reg_write(1, 800); reg_write(2, 0);
      reg_write(3, mk_ctl(8, 2, 1, 1, 1, 0));
      reg_write(4, 32'h5);
      wait_irq("R8 error irq");
      reg_read(5, d); check("R8 raw error", d == 2, d, 2);
      reg_read(7, d); check("R10 masked error", d == 2, d, 2);
      reg_read(4, d); check("R8 enable cleared", d[0] == 1'b0, d[0], 0);
      begin
         int seen;
         seen = 0;
         for (int i = 0; i < 10; i++) begin @(negedge clk); if (mem_req) seen++; end
         check("R8 no request after error", seen == 0, seen, 0);
      end
      clear_all();

      // R10 error with mask off
      acc_count = 0; err_at = 0;
      reg_write(4, 32'h1);
      repeat (30) @(negedge clk);
      reg_read(5, d); check("R10 raw error unmasked", d == 2, d, 2);
      check("R10 irq masked off", irq == 1'b0, irq, 0);
      reg_read(7, d); check("R10 masked status zero", d == 0, d, 0);
      err_at = -1;
      clear_all();

      // R9 hardware set coinciding with software clear
      rnd_gnt = 1'b0; wr_count = 0; collide_at = 2; collide_en = 1'b1;
      snap(); model_seg(30, 840, 3, 1, 1, 1);
      reg_write(0, 30); reg_write(1, 840); reg_write(2, 0);
      reg_write(3, mk_ctl(3, 1, 1, 1, 2, 0));
      reg_write(4, 32'h1);
      begin
         int n;
         n = 0;
         while (wr_count < 3 && n < 2000) begin @(negedge clk); n++; end
      end
      collide_en = 1'b0;
      repeat (2) @(negedge clk);
      reg_read(5, d); check("R9 set wins over clear", d == 1, d, 1);
      mem_compare("R9 collision data");
      clear_all();

      summary();
      $finish;
   end
endmodule